// File: doc/BRIEF.md
# Daisy-Chain RGB Driver Frame Transmitter

This block refreshes a chain of serially connected RGB LED driver nodes over four lines: serial data, serial clock, a latch strobe and an active-low output enable. A colour buffer inside the block holds one red, green and blue value per node and is loaded through a simple write port. Each channel is either a full 10-bit value or an 8-bit value. In 8-bit mode the byte is placed in the upper part of the 10-bit field.

A one-cycle `start` request, taken while the block is idle, runs one full refresh. The block first shifts one configuration word per node and latches them. It then shifts one colour word per node. Before the colour latch it blanks the drivers by driving the enable high. After the colour latch it waits a fixed settle time and then enables the drivers again. Every word is 32 bits long and is sent most significant bit first. Bit 31 is always 0. Bit 30 is 1 for a configuration word and 0 for a colour word. The word for node 0 goes out first, so it travels to the far end of the chain.

A free-running divider sets the serial rate. Each data bit takes three divider ticks: set the data, raise the clock, lower the clock. The buffer contents, the colour mode and the configuration fields are captured when a refresh is accepted. Writes made during a refresh therefore only show up in the next one.

Top module: `rgbchain_tx`

## Requirements
- R1: Each word is 32 bits sent MSB first, one rising `sd_clk` per bit. Bit 31 is 0. Bit 30 is 1 for a configuration word and 0 for a colour word.
- R2: With `color10`=1, a colour word carries blue in bits 29:20, red in bits 19:10 and green in bits 9:0, each taken as the full 10-bit buffered value.
- R3: With `color10`=0, each channel field is {value[7:0], 2'b00}. Bits 9:8 of the written value have no effect.
- R4: A configuration word is laid out as {0, 1, 00, 0, `dc_blu`[6:0], 000, `dc_red`[6:0], 0, `pwm_sel`[1:0], `dc_grn`[6:0]}. With all inputs zero the word is 32'h4000_0000.
- R5: A refresh sends NODES configuration words, then one latch pulse, then NODES colour words, then a second latch pulse. The latches come after exactly 32·NODES and 64·NODES clock pulses.
- R6: `sd_en_n` stays as it was through the configuration latch. It is high during the colour latch. It falls exactly SETTLE·DIV clock cycles after the colour latch falls.
- R7: The words for node 0 are shifted before those of higher nodes, in both the configuration and the colour part.
- R8: After reset, `sd_data`, `sd_clk` and `sd_latch` are 0, `sd_en_n` is 1, and `busy` and `done` are 0.
- R9: `sd_data` changes only while `sd_clk` is low and was low in the cycle before. `sd_clk` and `sd_latch` are never high together.
- R10: `busy` is 1 in the cycle after an accepted `start`. `done` is a one-cycle pulse in the cycle that `busy` falls. A `start` while busy is ignored and starts no second refresh.
- R11: Buffer writes made while a refresh is running do not change that refresh. They appear in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one refresh (taken when idle) |
| wr_en | input | 1 | Buffer write strobe |
| wr_node | input | NODE_W | Node index to write (0 is shifted first) |
| wr_red | input | 10 | Red value |
| wr_grn | input | 10 | Green value |
| wr_blu | input | 10 | Blue value |
| color10 | input | 1 | 1: 10-bit channels, 0: 8-bit channels |
| dc_red | input | 7 | Red dot-correction field |
| dc_grn | input | 7 | Green dot-correction field |
| dc_blu | input | 7 | Blue dot-correction field |
| pwm_sel | input | 2 | PWM clock mode field (00 = internal clock) |
| sd_data | output | 1 | Serial data |
| sd_clk | output | 1 | Serial clock |
| sd_latch | output | 1 | Latch strobe |
| sd_en_n | output | 1 | Active-low driver enable |
| busy | output | 1 | Refresh in progress |
| done | output | 1 | One-cycle pulse at the end of a refresh |

## Verification
`busy` is due one clock after `start` is sampled, so the bench drives `start` on a falling edge and reads `busy` on the next falling edge. The serial stream has no fixed phase against `start`, because the divider runs freely. A monitor therefore samples the lines on each falling edge. It records `sd_data` at every rising `sd_clk`, and it records the bit count and the enable level at every rising `sd_latch`. Words and latch positions are compared only after the `done` pulse, and they are compared by bit count rather than by cycle number. The settle delay is the one place where cycles are compared directly: the gap from the colour latch falling to the enable falling must be exactly SETTLE·DIV clocks, since both edges fall on divider ticks.

// File: rtl/rgbchain_pkg.sv
// Shared constants and types for the daisy-chain RGB frame transmitter.
// Assumes: one 32-bit word per node per frame, channels up to 10 bits wide.
package rgbchain_pkg;
    localparam int WORD_W = 32;
    localparam int CH_W   = 10;
    localparam int DC_W   = 7;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] blu;
    } rgb_t;

    typedef enum logic [2:0] {
        S_IDLE, S_CFG, S_CFG_LAT, S_COL, S_BLANK, S_COL_LAT, S_SETTLE
    } seq_t;
endpackage

// File: rtl/rgbchain_tick.sv
// Free-running divider: tick is high for one clk every DIV cycles.
// Assumes DIV >= 1; with DIV == 1 the tick is always high.
module rgbchain_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CNT_W = $clog2(DIV);
            logic [CNT_W-1:0] cnt;
            // Count 0..DIV-1 and wrap.
            always_ff @(posedge clk) begin
                if (!rst_n) cnt <= '0;
                else if (cnt == CNT_W'(DIV - 1)) cnt <= '0;
                else cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CNT_W'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/rgbchain_buf.sv
// Two-bank colour store. Writes land in the write bank; snap copies all
// nodes to the active bank, which feeds the shifter during a refresh.
// Assumes snap is asserted only when no refresh is in progress.
module rgbchain_buf
    import rgbchain_pkg::*;
#(
    parameter int NODES  = 2,
    parameter int NODE_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NODE_W-1:0] wr_node,
    input  rgb_t              wr_rgb,
    input  logic              snap,
    input  logic [NODE_W-1:0] rd_node,
    output rgb_t              rd_rgb
);
    rgb_t wr_bank  [NODES];
    rgb_t act_bank [NODES];

    generate
        for (genvar n = 0; n < NODES; n++) begin : g_node
            // Hold software-visible colour for node n.
            always_ff @(posedge clk) begin
                if (!rst_n) wr_bank[n] <= '0;
                else if (wr_en && wr_node == NODE_W'(n)) wr_bank[n] <= wr_rgb;
            end
            // Freeze node n's colour for the refresh being started.
            always_ff @(posedge clk) begin
                if (!rst_n) act_bank[n] <= '0;
                else if (snap) act_bank[n] <= wr_bank[n];
            end
        end
    endgenerate

    assign rd_rgb = act_bank[rd_node];
endmodule

// File: rtl/rgbchain_fmt.sv
// Builds the 32-bit configuration or colour word for one node.
// Assumes the caller holds all inputs stable while the word is shifted.
module rgbchain_fmt
    import rgbchain_pkg::*;
(
    input  logic              is_cfg,
    input  logic              wide,
    input  rgb_t              rgb,
    input  logic [DC_W-1:0]   dc_red,
    input  logic [DC_W-1:0]   dc_grn,
    input  logic [DC_W-1:0]   dc_blu,
    input  logic [1:0]        pwm_sel,
    output logic [WORD_W-1:0] word
);
    function automatic logic [CH_W-1:0] chan(input logic [CH_W-1:0] v, input logic w);
        return w ? v : {v[7:0], 2'b00};
    endfunction

    // Select the configuration or the colour layout.
    always_comb begin
        if (is_cfg)
            word = {1'b0, 1'b1, 2'b00, 1'b0, dc_blu, 3'b000, dc_red,
                    1'b0, pwm_sel, dc_grn};
        else
            word = {2'b00, chan(rgb.blu, wide), chan(rgb.red, wide),
                    chan(rgb.grn, wide)};
    end
endmodule

// File: rtl/rgbchain_tx.sv
// Top: runs one refresh per accepted start. Configuration words, latch,
// colour words, blank, latch, settle, enable. Each bit takes three ticks
// (data, clock high, clock low), so data only moves while clock is low.
// Assumes NODES >= 1, SETTLE >= 1, and start is a synchronous request.
module rgbchain_tx
    import rgbchain_pkg::*;
#(
    parameter int NODES  = 2,
    parameter int DIV    = 2,
    parameter int SETTLE = 20,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_en,
    input  logic [NODE_W-1:0] wr_node,
    input  logic [9:0]        wr_red,
    input  logic [9:0]        wr_grn,
    input  logic [9:0]        wr_blu,
    input  logic              color10,
    input  logic [6:0]        dc_red,
    input  logic [6:0]        dc_grn,
    input  logic [6:0]        dc_blu,
    input  logic [1:0]        pwm_sel,
    output logic              sd_data,
    output logic              sd_clk,
    output logic              sd_latch,
    output logic              sd_en_n,
    output logic              busy,
    output logic              done
);
    localparam int SET_W = $clog2(SETTLE + 1);

    seq_t              state;
    logic              tick;
    logic              accept;
    logic [NODE_W-1:0] node;
    logic [4:0]        bitn;
    logic [1:0]        phase;
    logic [SET_W-1:0]  wait_cnt;
    logic              wide_q;
    logic [DC_W-1:0]   dcr_q, dcg_q, dcb_q;
    logic [1:0]        pwm_q;
    rgb_t              cur_rgb;
    logic [WORD_W-1:0] word;

    assign accept = (state == S_IDLE) && start;

    rgbchain_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    rgbchain_buf #(.NODES(NODES), .NODE_W(NODE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_node(wr_node),
        .wr_rgb('{red: wr_red, grn: wr_grn, blu: wr_blu}),
        .snap(accept), .rd_node(node), .rd_rgb(cur_rgb)
    );

    rgbchain_fmt u_fmt (
        .is_cfg(state == S_CFG), .wide(wide_q), .rgb(cur_rgb),
        .dc_red(dcr_q), .dc_grn(dcg_q), .dc_blu(dcb_q), .pwm_sel(pwm_q),
        .word(word)
    );

    // Capture the frame settings when a refresh is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0; dcr_q <= '0; dcg_q <= '0; dcb_q <= '0; pwm_q <= '0;
        end else if (accept) begin
            wide_q <= color10; dcr_q <= dc_red; dcg_q <= dc_grn;
            dcb_q <= dc_blu; pwm_q <= pwm_sel;
        end
    end

    // Refresh sequencer and serial line drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; node <= '0; bitn <= 5'd31; phase <= 2'd0;
            wait_cnt <= '0; sd_data <= 1'b0; sd_clk <= 1'b0;
            sd_latch <= 1'b0; sd_en_n <= 1'b1; busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == S_IDLE) begin
                if (start) begin
                    busy <= 1'b1; state <= S_CFG; node <= '0;
                    bitn <= 5'd31; phase <= 2'd0;
                end
            end else if (tick) begin
                case (state)
                    S_CFG, S_COL: begin
                        case (phase)
                            2'd0: begin sd_data <= word[bitn]; phase <= 2'd1; end
                            2'd1: begin sd_clk <= 1'b1; phase <= 2'd2; end
                            default: begin
                                sd_clk <= 1'b0;
                                phase  <= 2'd0;
                                if (bitn == 5'd0) begin
                                    bitn <= 5'd31;
                                    if (node == NODE_W'(NODES - 1)) begin
                                        node  <= '0;
                                        state <= (state == S_CFG) ? S_CFG_LAT : S_BLANK;
                                    end else begin
                                        node <= node + 1'b1;
                                    end
                                end else begin
                                    bitn <= bitn - 1'b1;
                                end
                            end
                        endcase
                    end
                    S_CFG_LAT, S_COL_LAT: begin
                        if (phase == 2'd0) begin
                            sd_data <= 1'b0; sd_latch <= 1'b1; phase <= 2'd1;
                        end else begin
                            sd_latch <= 1'b0; phase <= 2'd0; wait_cnt <= '0;
                            state <= (state == S_CFG_LAT) ? S_COL : S_SETTLE;
                        end
                    end
                    S_BLANK: begin
                        sd_en_n <= 1'b1;
                        state   <= S_COL_LAT;
                    end
                    S_SETTLE: begin
                        if (wait_cnt == SET_W'(SETTLE - 1)) begin
                            sd_en_n <= 1'b0; busy <= 1'b0; done <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            wait_cnt <= wait_cnt + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rgbchain_tx_chk.sv
// Protocol checker for rgbchain_tx, attached with bind.
// Assumes clk and rst_n are those of the checked instance.
module rgbchain_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sd_data,
    input logic sd_clk,
    input logic sd_latch,
    input logic sd_en_n,
    input logic busy,
    input logic done
);
    AST_DATA_WHILE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_data) |-> (!sd_clk && !$past(sd_clk)));                  // R9
    AST_CLK_LATCH_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(sd_clk && sd_latch));                                               // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                      // R10
    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                                     // R10
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> busy);                                            // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sd_clk && !sd_latch));                                    // R5
    AST_ENABLED_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !sd_en_n);                                            // R6
endmodule

bind rgbchain_tx rgbchain_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .sd_data(sd_data),
    .sd_clk(sd_clk), .sd_latch(sd_latch), .sd_en_n(sd_en_n),
    .busy(busy), .done(done)
);

// File: tb/rgbchain_tx_test.sv
// Directed bench for rgbchain_tx. A monitor decodes the serial lines, and
// each scenario task compares the decoded words and latches with values
// built from the requirements.
module rgbchain_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int NODES  = 2;
    localparam int DIV    = 2;
    localparam int SETTLE = 20;

    logic clk = 0, rst_n = 0, start = 0, wr_en = 0, color10 = 1;
    logic [0:0] wr_node = '0;
    logic [9:0] wr_red = '0, wr_grn = '0, wr_blu = '0;
    logic [6:0] dc_red = '0, dc_grn = '0, dc_blu = '0;
    logic [1:0] pwm_sel = '0;
    logic sd_data, sd_clk, sd_latch, sd_en_n, busy, done;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    rgbchain_tx #(.NODES(NODES), .DIV(DIV), .SETTLE(SETTLE)) uut (
        .clk, .rst_n, .start, .wr_en, .wr_node, .wr_red, .wr_grn, .wr_blu,
        .color10, .dc_red, .dc_grn, .dc_blu, .pwm_sel,
        .sd_data, .sd_clk, .sd_latch, .sd_en_n, .busy, .done
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: decode the serial lines on falling clock edges.
    logic cap [0:4095];
    int nbits = 0, nlat = 0, ndone = 0, cyc = 0;
    int lat_pos [0:63];
    logic lat_en [0:63];
    int lat_fall_cyc = 0, en_fall_cyc = 0;
    logic p_clk = 0, p_lat = 0, p_en = 1;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sd_clk && !p_clk) begin cap[nbits] = sd_data; nbits++; end
            if (sd_latch && !p_lat) begin
                lat_pos[nlat] = nbits; lat_en[nlat] = sd_en_n; nlat++;
            end
            if (!sd_latch && p_lat) lat_fall_cyc = cyc;
            if (!sd_en_n && p_en) en_fall_cyc = cyc;
            if (done) ndone++;
        end
        p_clk = sd_clk; p_lat = sd_latch; p_en = sd_en_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input int pos);
        logic [31:0] w;
        for (int i = 0; i < 32; i++) w[31-i] = cap[pos+i];
        return w;
    endfunction

    function automatic logic [9:0] chf(input logic [9:0] v, input logic w);
        return w ? v : {v[7:0], 2'b00};
    endfunction

    function automatic logic [31:0] exp_col(input logic [9:0] r, g, b, input logic w);
        return {2'b00, chf(b, w), chf(r, w), chf(g, w)};
    endfunction

    function automatic logic [31:0] exp_cfg(input logic [6:0] r, g, b, input logic [1:0] m);
        return {1'b0, 1'b1, 2'b00, 1'b0, b, 3'b000, r, 1'b0, m, g};
    endfunction

    task automatic wr(input int node, input logic [9:0] r, g, b);
        @(negedge clk);
        wr_en = 1; wr_node = node[0:0]; wr_red = r; wr_grn = g; wr_blu = b;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R10 busy after start", {31'd0, busy}, 32'd1);
    endtask

    task automatic wait_done();
        int d0 = ndone;
        while (ndone == d0) @(negedge clk);
        @(negedge clk);
    endtask

    // Settings are kept in the bench so that expected words are built here.
    logic [9:0] r0 = 10'h3A5, g0 = 10'h15C, b0 = 10'h2F0;
    logic [9:0] r1 = 10'h001, g1 = 10'h3FF, b1 = 10'h200;

    task automatic t_reset();
        chk("R8 reset data/clk/latch", {29'd0, sd_data, sd_clk, sd_latch}, 32'd0);
        chk("R8 reset enable high", {31'd0, sd_en_n}, 32'd1);
        chk("R8 reset busy/done", {30'd0, busy, done}, 32'd0);
    endtask

    task automatic t_basic10();
        int b0i = nbits, l0 = nlat, d0 = ndone;
        wr(0, r0, g0, b0); wr(1, r1, g1, b1);
        color10 = 1;
        pulse_start(); wait_done();
        chk("R5 bit count", nbits - b0i, 64 * NODES);
        chk("R4 R1 cfg word node0", word_at(b0i), 32'h4000_0000);
        chk("R4 cfg word node1", word_at(b0i + 32), 32'h4000_0000);
        chk("R2 R7 colour node0 first", word_at(b0i + 64), exp_col(r0, g0, b0, 1));
        chk("R2 colour node1", word_at(b0i + 96), exp_col(r1, g1, b1, 1));
        chk("R5 latch count", nlat - l0, 2);
        chk("R5 cfg latch position", lat_pos[l0] - b0i, 32 * NODES);
        chk("R5 colour latch position", lat_pos[l0+1] - b0i, 64 * NODES);
        chk("R6 blanked at colour latch", {31'd0, lat_en[l0+1]}, 32'd1);
        chk("R6 settle delay", en_fall_cyc - lat_fall_cyc, SETTLE * DIV);
        chk("R6 enabled after refresh", {31'd0, sd_en_n}, 32'd0);
        chk("R10 one done pulse", ndone - d0, 1);
        chk("R10 busy dropped", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_mode8();
        int b0i = nbits;
        logic [9:0] r = 10'h3C3, g = 10'h1A5, b = 10'h27E;
        wr(0, r, g, b);
        color10 = 0;
        pulse_start(); color10 = 1; wait_done();
        chk("R3 8-bit colour node0", word_at(b0i + 64), exp_col(r, g, b, 0));
        chk("R3 8-bit colour node1", word_at(b0i + 96), exp_col(r1, g1, b1, 0));
        r0 = r; g0 = g; b0 = b;
    endtask

    task automatic t_cfg();
        int b0i = nbits, l0 = nlat;
        dc_red = 7'h55; dc_grn = 7'h2A; dc_blu = 7'h7F; pwm_sel = 2'b10;
        pulse_start();
        dc_red = 0; dc_grn = 0; dc_blu = 0; pwm_sel = 0;
        wait_done();
        chk("R4 cfg fields node0", word_at(b0i), exp_cfg(7'h55, 7'h2A, 7'h7F, 2'b10));
        chk("R4 R7 cfg fields node1", word_at(b0i + 32), exp_cfg(7'h55, 7'h2A, 7'h7F, 2'b10));
        chk("R6 enable unchanged at cfg latch", {31'd0, lat_en[l0]}, 32'd0);
    endtask

    task automatic t_busy();
        int b0i = nbits, d0 = ndone, b1i;
        logic [9:0] nr = 10'h2AA, ng = 10'h155, nb = 10'h0F0;
        pulse_start();
        repeat (100) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
        wr(1, nr, ng, nb);
        wait_done();
        chk("R11 old colour kept in running refresh", word_at(b0i + 96), exp_col(r1, g1, b1, 1));
        repeat (60) @(negedge clk);
        chk("R10 start while busy ignored (bits)", nbits - b0i, 64 * NODES);
        chk("R10 start while busy ignored (done)", ndone - d0, 1);
        chk("R10 idle after ignored start", {31'd0, busy}, 32'd0);
        b1i = nbits;
        pulse_start(); wait_done();
        chk("R11 new colour in next refresh", word_at(b1i + 96), exp_col(nr, ng, nb, 1));
        chk("R7 node0 unchanged", word_at(b1i + 64), exp_col(r0, g0, b0, 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic10();
        t_mode8();
        t_cfg();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule